// File: doc/BRIEF.md
# Selectable-Input Programmable Clock Divider

This block takes two reference clocks, picks one of them with a select input, and divides the chosen clock by one of eight fixed ratios: 1, 2, 3, 4, 5, 6, 8 or 16. A 3-bit code chooses the ratio. The divided clock leaves the block on a single output pin. An enable input can release that pin to high impedance, so several sources can share one clock net.

Even ratios toggle the output every N/2 input cycles. Odd ratios combine a count made on the rising edge with a copy of it retimed on the falling edge, which gives an exact 50% duty cycle. Ratio 1 is a gated pass-through of the selected clock. A new code is accepted only when the counter reaches the end of an output period, so a change of ratio never cuts an output pulse short. Reset is synchronous to the selected clock and active high.

Top module: `clkdiv_fanout`

## Requirements
- R1: When `clk_sel_i` is 0 the output is derived from `clk0_i`. When it is 1 the output is derived from `clk1_i`.
- R2: `div_code_i` selects the divide ratio: 0→1, 1→2, 2→3, 3→4, 4→5, 5→6, 6→8, 7→16. The output period equals ratio × the period of the selected input.
- R3: For every ratio the output high time lies between 40% and 60% of the output period. Odd ratios reach exactly half by using a falling-edge-retimed copy of the count.
- R4: At ratio 1 (code 0) the output follows the selected input clock, with the same period and the same high time.
- R5: The block samples a new code only at the end of the current output period. The pulse in progress keeps the length set by the old ratio, and the following periods use the new ratio.
- R6: While `oe_i` is 0 the output pin is high impedance. While `oe_i` is 1 the pin drives the divided clock.
- R7: While `rst_i` is high on edges of the selected clock, the counter is cleared, the code is reloaded and the output is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | First reference clock |
| clk1_i | input | 1 | Second reference clock |
| clk_sel_i | input | 1 | Reference select: 0 first, 1 second |
| rst_i | input | 1 | Synchronous active-high reset, sampled on the selected clock |
| div_code_i | input | 3 | Divide ratio code |
| oe_i | input | 1 | Output enable; 0 releases the pin |
| clk_o | output | 1 | Divided clock, or high impedance |

## Verification
The code update and the output period boundary can meet in the same cycle. A ratio change that lands in the middle of a long high phase must not shorten that phase. The bench provokes this by running at ratio 16 and rewriting the code three input cycles after an output rising edge. It then checks that this high phase is still eight input periods long, that the full period is sixteen, and that the next period is two. Release of the pin is judged against a pull-up on the bench net: while the enable is low, a divider that would otherwise toggle every input cycle must leave the net steadily high.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CODE_W = 3;
  localparam int CNT_W  = 5;

  // map a divide code onto its ratio
  function automatic logic [CNT_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] r;
    case (code)
      3'd0:    r = CNT_W'(1);
      3'd1:    r = CNT_W'(2);
      3'd2:    r = CNT_W'(3);
      3'd3:    r = CNT_W'(4);
      3'd4:    r = CNT_W'(5);
      3'd5:    r = CNT_W'(6);
      3'd6:    r = CNT_W'(8);
      default: r = CNT_W'(16);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_select.sv
`timescale 1ns/1ps
module clkdiv_select (
  input  logic clk0_i,
  input  logic clk1_i,
  input  logic sel_i,
  output logic clk_o
);
  assign clk_o = sel_i ? clk1_i : clk0_i;
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int CNT_W = clkdiv_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             div_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ratio_q_o,
  output logic             pos_o,
  output logic             run_o
);
  logic [CNT_W-1:0] cnt_q, n_q, cnt_nxt, n_nxt, hi_len;
  logic             pos_q, neg_q, run_q, wrap;

  assign wrap    = (cnt_q == n_q - CNT_W'(1));
  assign cnt_nxt = wrap ? '0 : cnt_q + CNT_W'(1);
  assign n_nxt   = wrap ? ratio_i : n_q;
  assign hi_len  = CNT_W'((n_q + CNT_W'(1)) >> 1);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= ratio_i - CNT_W'(1);
      n_q   <= ratio_i;
      pos_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      n_q   <= n_nxt;
      pos_q <= wrap | (cnt_nxt < hi_len);
      run_q <= 1'b1;
    end
  end

  // falling-edge copy for odd ratios
  always_ff @(negedge clk_i) begin
    if (rst_i) neg_q <= 1'b0;
    else       neg_q <= pos_q;
  end

  always_comb begin
    if (n_q == CNT_W'(1))  div_o = clk_i & run_q;
    else if (n_q[0])       div_o = pos_q & neg_q;
    else                   div_o = pos_q;
  end

  assign cnt_o     = cnt_q;
  assign ratio_q_o = n_q;
  assign pos_o     = pos_q;
  assign run_o     = run_q;
endmodule

// File: rtl/clkdiv_drive.sv
`timescale 1ns/1ps
module clkdiv_drive (
  input  logic en_i,
  input  logic d_i,
  output logic pad_o
);
  assign pad_o = en_i ? d_i : 1'bz;
endmodule

// File: rtl/clkdiv_fanout.sv
`timescale 1ns/1ps
module clkdiv_fanout #(
  parameter int CODE_W = clkdiv_pkg::CODE_W,
  parameter int CNT_W  = clkdiv_pkg::CNT_W
) (
  input  logic              clk0_i,
  input  logic              clk1_i,
  input  logic              clk_sel_i,
  input  logic              rst_i,
  input  logic [CODE_W-1:0] div_code_i,
  input  logic              oe_i,
  output logic              clk_o
);
  logic             sel_clk, div_w, pos_w, run_w;
  logic [CNT_W-1:0] ratio_w, cnt_w, n_w;

  assign ratio_w = clkdiv_pkg::code_to_ratio(div_code_i);

  clkdiv_select u_sel (
    .clk0_i(clk0_i), .clk1_i(clk1_i), .sel_i(clk_sel_i), .clk_o(sel_clk)
  );

  clkdiv_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(sel_clk), .rst_i(rst_i), .ratio_i(ratio_w), .div_o(div_w),
    .cnt_o(cnt_w), .ratio_q_o(n_w), .pos_o(pos_w), .run_o(run_w)
  );

  clkdiv_drive u_drv (
    .en_i(oe_i), .d_i(div_w), .pad_o(clk_o)
  );
endmodule

// File: rtl/clkdiv_checker.sv
`timescale 1ns/1ps
module clkdiv_checker #(
  parameter int CNT_W = clkdiv_pkg::CNT_W
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] n,
  input logic             pos,
  input logic             run
);
  assert_rst_clear_R7: assert property (@(posedge clk) rst |=> (!pos && !run));

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt < n);

  assert_ratio_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(n) |-> (cnt == '0));

  assert_rise_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pos) |-> (cnt == '0));
endmodule

bind clkdiv_fanout clkdiv_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(sel_clk), .rst(rst_i), .cnt(cnt_w), .n(n_w), .pos(pos_w), .run(run_w)
);

// File: tb/clkdiv_fanout_bench.sv
`timescale 1ns/1ps
module clkdiv_fanout_bench;
  localparam real T0 = 20.0;
  localparam real T1 = 30.0;

  logic       clk0 = 1'b0, clk1 = 1'b0;
  logic       clk_sel = 1'b0, rst = 1'b1, oe = 1'b1;
  logic [2:0] code = 3'd0;
  wire        q_w;
  int         total = 0, bad = 0;

  pullup (q_w);

  always #10 clk0 = ~clk0;
  initial begin
    #2;
    forever #15 clk1 = ~clk1;
  end

  clkdiv_fanout u_clkdiv_fanout (
    .clk0_i(clk0), .clk1_i(clk1), .clk_sel_i(clk_sel), .rst_i(rst),
    .div_code_i(code), .oe_i(oe), .clk_o(q_w)
  );

  function automatic int ratio_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
      3'd4: return 5;  3'd5: return 6;  3'd6: return 8;  default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0.3f expected=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(posedge clk0); #3 rst = 1'b1;
    repeat (6) @(posedge clk0);
    #3 rst = 1'b0;
  endtask

  // R7: output low while reset is held
  task automatic t_reset_low();
    clk_sel = 1'b0; code = 3'd0; oe = 1'b1;
    @(posedge clk0); #3 rst = 1'b1;
    repeat (4) @(posedge clk0);
    for (int i = 0; i < 6; i++) begin
      #4;
      chk(q_w === 1'b0, "R7", "output during reset", real'(q_w), 0.0);
    end
    #3 rst = 1'b0;
  endtask

  // R1 R2 R3 R4: period and duty for one code on one clock
  task automatic t_ratio(input logic sel, input logic [2:0] c);
    real tin, t0, t1, t2, per, hi;
    int  n;
    n   = ratio_of(c);
    tin = sel ? T1 : T0;
    clk_sel = sel; code = c;
    apply_reset();
    repeat (2) @(posedge q_w);
    t0 = $realtime;
    @(negedge q_w); t1 = $realtime;
    @(posedge q_w); t2 = $realtime;
    per = t2 - t0;
    hi  = t1 - t0;
    chk((per > n*tin - 0.5) && (per < n*tin + 0.5),
        sel ? "R1 R2 clk1" : "R1 R2 clk0", $sformatf("period code=%0d", c), per, n*tin);
    chk((hi >= 0.4*per) && (hi <= 0.6*per), "R3",
        $sformatf("duty code=%0d sel=%0d", c, sel), hi/per, 0.5);
    if (c == 3'd0)
      chk((hi > tin/2.0 - 0.5) && (hi < tin/2.0 + 0.5), "R4",
          $sformatf("pass-through high time sel=%0d", sel), hi, tin/2.0);
  endtask

  // R6: released pin stays at the bench pull-up level
  task automatic t_tristate();
    real t0, t1;
    int  low_seen;
    low_seen = 0;
    clk_sel = 1'b0; code = 3'd1;
    apply_reset();
    #3 oe = 1'b0;
    for (int i = 0; i < 40; i++) begin
      #7;
      if (q_w !== 1'b1) low_seen++;
    end
    chk(low_seen == 0, "R6", "samples not released while disabled", real'(low_seen), 0.0);
    oe = 1'b1;
    repeat (2) @(posedge q_w);
    t0 = $realtime;
    @(posedge q_w); t1 = $realtime;
    chk((t1 - t0 > 2*T0 - 0.5) && (t1 - t0 < 2*T0 + 0.5), "R6",
        "driven period after enable", t1 - t0, 2*T0);
  endtask

  // R5: change of code in the middle of a long high phase
  task automatic t_code_change();
    real tr, tf, t2, t3, t4;
    clk_sel = 1'b0; code = 3'd7;
    apply_reset();
    @(posedge q_w); tr = $realtime;
    repeat (3) @(posedge clk0);
    #3 code = 3'd1;
    @(negedge q_w); tf = $realtime;
    chk((tf - tr > 8*T0 - 0.5) && (tf - tr < 8*T0 + 0.5), "R5",
        "high phase kept after code change", tf - tr, 8*T0);
    @(posedge q_w); t2 = $realtime;
    chk((t2 - tr > 16*T0 - 0.5) && (t2 - tr < 16*T0 + 0.5), "R5",
        "old period completed", t2 - tr, 16*T0);
    @(posedge q_w); t3 = $realtime;
    @(posedge q_w); t4 = $realtime;
    chk((t4 - t3 > 2*T0 - 0.5) && (t4 - t3 < 2*T0 + 0.5), "R5",
        "new ratio in force", t4 - t3, 2*T0);
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_low();
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        t_ratio(s[0], c[2:0]);
    t_tristate();
    t_code_change();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule